// File: doc/BRIEF.md
# Interleaved 20-to-1 Word Serializer

This block turns a parallel word into a serial bit stream that runs at twenty times the word rate. Once per word period it captures the parallel input into a word register. It then spreads the bits over four short shift lanes with a fixed interleave: lane *r* holds every fourth bit, starting at bit *r*. A two-level multiplexer tree merges the lane heads into one line. The two first-level nodes each produce one half-rate stream, one for the odd-numbered bits and one for the even-numbered bits. The root node alternates between these two streams on every bit.

All clock phases are modelled with a single clock running at the serial bit rate. A phase counter produces the word-capture strobe, the lane-load strobe, the lane-shift strobe and the multiplexer selects. A source upstream watches `take` and presents the next word in that cycle. The block then sends the words back to back with no idle bits between them. `frame` marks the cycle that carries the first bit of each word.

Bit numbering: bit *k* (1 to 20) is `din[k-1]`.

Top module: `ilv_serializer`

## Requirements
- R1: During synchronous reset, and in the cycles that follow it, `sout`, `frame` and `take` are low. `sout` stays low until the first bit of the first captured word appears.
- R2: Cycles are counted from 0, where cycle 0 is the first cycle with `rst` low. `take` is high in cycle 18 and then in every 20th cycle after it, and low in all other cycles. `din` is captured at the clock edge that ends a `take` cycle.
- R3: The value on `din` in any cycle where `take` is low has no effect on `sout`.
- R4: For a word captured at the end of `take` cycle T, bit k (`din[k-1]`) is driven on `sout` in cycle T+2+k, for k = 1 to 20. The order is therefore bit 1 first and bit 20 last.
- R5: Words captured in consecutive `take` cycles are sent without a gap. Bit 1 of a word immediately follows bit 20 of the previous word.
- R6: `frame` is high exactly in the cycles where `sout` carries bit 1 of a captured word, and low in every other cycle.
- R7: The lanes and the multiplexer tree together place every input position in its own serial slot. A word with one bit set produces exactly one high slot, at that bit's position. A word with one bit clear produces exactly one low slot, at that bit's position.
- R8: Asserting reset in the middle of a word drops that word. `sout` and `frame` are low in the cycle after the reset edge, and the timing of R2 restarts when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WORD_W | Parallel word; bit k of the stream is `din[k-1]` |
| take | output | 1 | High in the cycle whose closing edge captures `din` |
| sout | output | 1 | Serial data, one bit per clock |
| frame | output | 1 | High while `sout` carries bit 1 of a word |

## Verification
A wrong interleave or a wrong select wiring in the tree keeps the number of ones the same but moves a bit to another slot of the same word. A walking single-bit word shows this within three cycles after the affected slot starts. An error in the phase counter or in load timing moves `take` and `frame` out of their 20-cycle grid, so it shows up within one word period. A word register that updates outside its capture edge, or a lane that loads or shifts at the wrong phase, corrupts the word that is being sent. This becomes visible only when that word's bits reach the line, up to 22 cycles after the fault. For that reason the stream is compared slot by slot over many consecutive words, while `din` is kept busy with unrelated values between captures.

// File: rtl/ilv_ser_pkg.sv
`timescale 1ns/1ps
package ilv_ser_pkg;

    // Default geometry: one word of 20 bits spread over 4 lanes.
    localparam int unsigned DEF_WORD_W = 20;
    localparam int unsigned DEF_LANES  = 4;

    // Strobes decoded from the phase counter once per fast cycle.
    typedef struct packed {
        logic take;      // word register captures din at the closing edge
        logic load;      // lanes load from the word register at the closing edge
        logic shift;     // lanes advance one slot at the closing edge
        logic first_ph;  // phase in which bit 1 sits on the registered output
    } ilv_strobe_t;

    // Number of slots per lane.
    function automatic int unsigned lane_depth(int unsigned word_w, int unsigned lanes);
        return word_w / lanes;
    endfunction

    // Word bit index (0-based) held in a given lane slot.
    function automatic int unsigned src_index(int unsigned lane, int unsigned slot,
                                              int unsigned lanes);
        return slot * lanes + lane;
    endfunction

    // Reverse the lowest w bits of v. It maps a leaf position of the mux tree
    // to the lane whose residue that leaf selects.
    function automatic int unsigned bitrev(int unsigned v, int unsigned w);
        int unsigned r;
        r = 0;
        for (int b = 0; b < int'(w); b++) begin
            if (v[b]) r = r | (32'd1 << (w - 1 - b));
        end
        return r;
    endfunction

endpackage

// File: rtl/ilv_phase_gen.sv
`timescale 1ns/1ps
module ilv_phase_gen #(
    parameter int unsigned WORD_W = ilv_ser_pkg::DEF_WORD_W,
    parameter int unsigned LANES  = ilv_ser_pkg::DEF_LANES,
    localparam int unsigned PH_W  = $clog2(WORD_W),
    localparam int unsigned SEL_W = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [PH_W-1:0]           ph,
    output logic [SEL_W-1:0]          sel,
    output ilv_ser_pkg::ilv_strobe_t  stb
);
    localparam int unsigned LAST_PH = WORD_W - 1;
    localparam int unsigned TAKE_PH = WORD_W - 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (ph == PH_W'(LAST_PH)) begin
            ph <= '0;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    // WORD_W is a multiple of LANES, which is a power of two, so the low
    // bits of the phase are the residue modulo LANES.
    assign sel = ph[SEL_W-1:0];

    always_comb begin
        stb.take     = (ph == PH_W'(TAKE_PH));
        stb.load     = (ph == PH_W'(LAST_PH));
        stb.shift    = (sel == SEL_W'(LANES - 1)) && !stb.load;
        stb.first_ph = (ph == PH_W'(1));
    end

endmodule

// File: rtl/ilv_word_latch.sv
`timescale 1ns/1ps
module ilv_word_latch #(
    parameter int unsigned WORD_W = ilv_ser_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end
endmodule

// File: rtl/ilv_shift_lane.sv
`timescale 1ns/1ps
module ilv_shift_lane #(
    parameter int unsigned DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [DEPTH-1:0] pdata,
    output logic             head
);
    logic [DEPTH-1:0] slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (load) begin
            slots <= pdata;
        end else if (shift) begin
            slots <= {1'b0, slots[DEPTH-1:1]};
        end
    end

    assign head = slots[0];
endmodule

// File: rtl/ilv_mux_tree.sv
`timescale 1ns/1ps
module ilv_mux_tree #(
    parameter int unsigned LANES  = ilv_ser_pkg::DEF_LANES,
    localparam int unsigned SEL_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] lane_in,
    input  logic [SEL_W-1:0] sel,
    output logic             out
);
    // Heap-ordered tree: node 1 is the root and nodes LANES..2*LANES-1 are
    // leaves. A node at depth d is steered by sel[d]. The root therefore
    // uses the fastest-toggling bit (odd/even bit alternation), and the
    // first level below it uses the next bit (lane pair within a stream).
    logic [2*LANES-1:1] node;

    for (genvar o = 0; o < LANES; o++) begin : g_leaf
        localparam int unsigned SRC = ilv_ser_pkg::bitrev(o, SEL_W);
        assign node[LANES + o] = lane_in[SRC];
    end

    for (genvar i = 1; i < LANES; i++) begin : g_node
        localparam int unsigned DEP = $clog2(i + 1) - 1;
        assign node[i] = sel[DEP] ? node[2*i + 1] : node[2*i];
    end

    assign out = node[1];
endmodule

// File: rtl/ilv_serializer.sv
`timescale 1ns/1ps
module ilv_serializer #(
    parameter int unsigned WORD_W = ilv_ser_pkg::DEF_WORD_W,
    parameter int unsigned LANES  = ilv_ser_pkg::DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    output logic              take,
    output logic              sout,
    output logic              frame
);
    localparam int unsigned DEPTH = ilv_ser_pkg::lane_depth(WORD_W, LANES);
    localparam int unsigned PH_W  = $clog2(WORD_W);
    localparam int unsigned SEL_W = $clog2(LANES);

    logic [PH_W-1:0]          ph;
    logic [SEL_W-1:0]         sel;
    ilv_ser_pkg::ilv_strobe_t stb;
    logic [WORD_W-1:0]        latch_q;
    logic [DEPTH-1:0]         lane_pd [LANES];
    logic [LANES-1:0]         lane_head;
    logic                     tree_out;
    logic                     sout_q;
    logic                     primed;

    ilv_phase_gen #(.WORD_W(WORD_W), .LANES(LANES)) u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .sel (sel),
        .stb (stb)
    );

    ilv_word_latch #(.WORD_W(WORD_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .cap (stb.take),
        .d   (din),
        .q   (latch_q)
    );

    // Lane gl, slot gs carries word bit gs*LANES+gl (interleaved by residue).
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        for (genvar gs = 0; gs < DEPTH; gs++) begin : g_slot
            localparam int unsigned IDX = ilv_ser_pkg::src_index(gl, gs, LANES);
            assign lane_pd[gl][gs] = latch_q[IDX];
        end

        ilv_shift_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .load  (stb.load),
            .shift (stb.shift),
            .pdata (lane_pd[gl]),
            .head  (lane_head[gl])
        );
    end

    ilv_mux_tree #(.LANES(LANES)) u_tree (
        .lane_in (lane_head),
        .sel     (sel),
        .out     (tree_out)
    );

    // Registered line output; primed marks that a real word has been loaded.
    always_ff @(posedge clk) begin
        if (rst) begin
            sout_q <= 1'b0;
            primed <= 1'b0;
        end else begin
            sout_q <= tree_out;
            if (stb.load) primed <= 1'b1;
        end
    end

    assign take  = stb.take;
    assign sout  = sout_q;
    assign frame = primed && stb.first_ph;

endmodule

// File: rtl/ilv_serializer_chk.sv
`timescale 1ns/1ps
module ilv_serializer_chk #(
    parameter int unsigned WORD_W = ilv_ser_pkg::DEF_WORD_W,
    parameter int unsigned LANES  = ilv_ser_pkg::DEF_LANES,
    localparam int unsigned PH_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [PH_W-1:0]   ph,
    input logic              take,
    input logic              load,
    input logic [WORD_W-1:0] latch_q,
    input logic [LANES-1:0]  lane_head,
    input logic              sout,
    input logic              frame
);
    localparam int unsigned LAST_PH = WORD_W - 1;

    logic seen_load;
    always_ff @(posedge clk) begin
        if (rst) seen_load <= 1'b0;
        else if (load) seen_load <= 1'b1;
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_W'(LAST_PH)) |=> (ph == $past(ph) + PH_W'(1)));            // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_W'(LAST_PH)) |=> (ph == '0));                              // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(latch_q));                                         // R3
    AST_LOAD_HEAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (lane_head[0] == $past(latch_q[0])));                       // R4
    AST_QUIET_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !seen_load |-> !sout);                                               // R1
    AST_FRAME_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> ##1 frame);                                                 // R6
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame |=> !frame);                                                   // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!sout && !frame));                                          // R8

endmodule

bind ilv_serializer ilv_serializer_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .take      (take),
    .load      (stb.load),
    .latch_q   (latch_q),
    .lane_head (lane_head),
    .sout      (sout),
    .frame     (frame)
);

// File: tb/sim_ilv_serializer.sv
`timescale 1ns/1ps
module sim_ilv_serializer;
    localparam int W = 20;
    localparam int L = 4;
    localparam int P = W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         take;
    logic         sout;
    logic         frame;

    ilv_serializer #(.WORD_W(W), .LANES(L)) u0 (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .take  (take),
        .sout  (sout),
        .frame (frame)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bit exp_s [int];
    bit exp_f [int];
    int cyc       = 0;
    int first_cyc = -1;
    int widx      = 0;
    logic [31:0] lfsr_w = 32'h1ACE5EED;
    logic [31:0] lfsr_g = 32'h0BADF00D;

    function automatic logic [31:0] nxt(logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'hA300_0001) : (s >> 1);
    endfunction

    // Word sequence: walking one, walking zero, fixed patterns, then pseudo-random.
    function automatic logic [W-1:0] word_for(int i);
        if (i < W)          return W'(1) << i;
        else if (i < 2*W)   return ~(W'(1) << (i - W));
        else if (i == 2*W)   return '0;
        else if (i == 2*W+1) return '1;
        else if (i == 2*W+2) return W'(20'h55555);
        else if (i == 2*W+3) return W'(20'hAAAAA);
        lfsr_w = nxt(lfsr_w);
        return lfsr_w[W-1:0];
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic sample(string tag);
        bit e_take;
        bit e_s;
        bit e_f;
        string rq;
        e_take = ((cyc % P) == P - 2);
        e_s    = exp_s.exists(cyc) ? exp_s[cyc] : 1'b0;
        e_f    = exp_f.exists(cyc);
        rq     = (first_cyc < 0 || cyc < first_cyc) ? "R1" : tag;
        check(take === e_take, "R2", int'(take), int'(e_take), "take");
        check(sout === e_s, rq, int'(sout), int'(e_s), "sout");
        check(frame === e_f, "R6", int'(frame), int'(e_f), "frame");
    endtask

    // Record the expected stream for a word captured at the end of cycle t (R4).
    task automatic schedule(int t, logic [W-1:0] w);
        for (int k = 1; k <= W; k++) exp_s[t + 2 + k] = w[k-1];
        exp_f[t + 3] = 1'b1;
        if (first_cyc < 0) first_cyc = t + 3;
    endtask

    // Run n cycles. In capture cycles a sequence word is driven, and in all
    // other cycles unrelated values are driven (R3).
    task automatic run(int n, string tag);
        for (int c = 0; c < n; c++) begin
            sample(tag);
            if ((cyc % P) == P - 2) begin
                din = word_for(widx);
                widx++;
                schedule(cyc, din);
            end else begin
                lfsr_g = nxt(lfsr_g);
                din = lfsr_g[W-1:0];
            end
            step();
            cyc++;
        end
    endtask

    task automatic do_reset(int n);
        rst = 1'b1;
        for (int c = 0; c < n; c++) begin
            lfsr_g = nxt(lfsr_g);
            din = lfsr_g[W-1:0];
            step();
            check(sout === 1'b0, "R8", int'(sout), 0, "sout in reset");
            check(frame === 1'b0, "R8", int'(frame), 0, "frame in reset");
            check(take === 1'b0, "R1", int'(take), 0, "take in reset");
        end
        rst = 1'b0;
        exp_s.delete();
        exp_f.delete();
        cyc = 0;
        first_cyc = -1;
    endtask

    initial begin
        do_reset(3);
        run(2 * W * P, "R7");      // walking one and walking zero
        run(4 * P, "R4");          // fixed patterns
        run(100 * P, "R5");        // back-to-back pseudo-random words
        run(9, "R5");              // stop partway into a word
        do_reset(3);               // R8: drop it mid-stream
        run(6 * P + 25, "R3");     // restart, din busy between captures
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule